// File: doc/BRIEF.md
# System-Control Status/Cause Controller

This block keeps the processor-mode and exception bookkeeping for a small 32-bit RISC core. It holds a Status register, a Cause register and a bank of plain system registers, one of which serves as the exception return address. The core writes these registers through an indexed write port. It signals exception entry with a 5-bit code, a delay-slot flag and the faulting PC. It requests a return from exception with a one-cycle pop strobe.

Status bits 5:0 form a three-level mode stack. Each level is a kernel/user bit paired with an interrupt-enable bit. Exception entry pushes the stack and return pops it. Software can set only the two software-interrupt bits of Cause. A write to Status or Cause re-evaluates whether a software interrupt is due. If one is due, the block raises `irq_take` in the following cycle and performs an interrupt-type entry with code 0 on the next edge.

Top module: `cp0_sysctl`

## Requirements
- R1: During and after reset, Status, Cause, every bank register and `irq_take` are zero.
- R2: A write to index 12 replaces all 32 bits of Status on the next edge.
- R3: A write to index 13 changes only Cause bits 9:8, taken from the write data. All other Cause bits keep their value.
- R4: A write to any index other than 12 and 13 stores the full word, which reads back on `rd_data` when `rd_idx` selects it. Indices 12 and 13 read Status and Cause. Index 14 holds the exception return address.
- R5: `irq_take` is high only in the cycle right after an applied write to index 12 or 13. It also requires that `(Cause & Status & 0x300)` is nonzero, that Status bit 0 is 1, and that `exc_req` is low in that cycle.
- R6: On the edge that ends an `irq_take` cycle, the code field Cause[6:2] becomes 0 and Cause[31] takes `exc_in_delay`. Index 14 takes `exc_pc` and the mode stack is pushed.
- R7: On an edge with `exc_req` high, Cause[6:2] takes `exc_code` and Cause[31] takes `exc_in_delay`. Index 14 takes `exc_pc` and Status[5:0] becomes {Status[3:0], 2'b00}. Status bits 31:6 and Cause bits 30:7 and 1:0 keep their value.
- R8: An entry with code 8 (system call) leaves the value 0x20 in Cause bits 6:0 when Cause bits 1:0 are zero.
- R9: A pop strobe sets Status[3:0] to Status[5:2] and leaves Status bits 31:4 unchanged.
- R10: Only one action is applied per edge, in this priority: exception entry, interrupt take, pop, register write. Any lower-priority request in the same cycle is dropped without effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write request |
| wr_idx | input | 5 | Register index for the write |
| wr_data | input | 32 | Write data |
| exc_req | input | 1 | Exception entry request |
| exc_code | input | 5 | Exception code for the entry |
| exc_in_delay | input | 1 | Faulting instruction sat in a branch delay slot |
| exc_pc | input | 32 | Return address captured on any entry |
| rfe | input | 1 | Return-from-exception mode-stack pop |
| rd_idx | input | 5 | Register index for the read port |
| status_q | output | 32 | Current Status register |
| cause_q | output | 32 | Current Cause register |
| rd_data | output | 32 | Register selected by rd_idx |
| irq_take | output | 1 | Software interrupt being taken this cycle |

## Verification
Every register result appears one edge after the cycle that requests it. `irq_take` comes up in the cycle after the write edge, and its interrupt entry lands one edge later again. The driver drives each cycle's inputs at the falling edge and updates a reference model on the following rising edge. It then queues the values due in the cycle that edge opens. The monitor pops and compares the queue 2 ns after that rising edge, before any new input is driven, so combinational `irq_take` is judged against the inputs that actually gate it.

// File: rtl/cp0_pkg.sv
package cp0_pkg;
    parameter int XLEN = 32;
    parameter int NREG = 32;
    localparam int IDX_W = $clog2(NREG);

    localparam int IDX_STATUS = 12;
    localparam int IDX_CAUSE  = 13;
    localparam int IDX_EPC    = 14;

    localparam int CODE_W  = 5;
    localparam int CODE_LO = 2;
    localparam int BD_BIT  = XLEN - 1;
    localparam int SWI_LO  = 8;
    localparam int SWI_W   = 2;
    localparam int MODE_W  = 6;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_ENTER,
        ACT_TAKE,
        ACT_POP,
        ACT_WRITE
    } act_e;

    typedef struct packed {
        logic              bd;
        logic [CODE_W-1:0] code;
        logic [XLEN-1:0]   pc;
    } entry_t;

    function automatic logic [XLEN-1:0] mode_push(input logic [XLEN-1:0] s);
        logic [XLEN-1:0] r;
        r = s;
        r[MODE_W-1:0] = {s[MODE_W-3:0], 2'b00};
        return r;
    endfunction

    function automatic logic [XLEN-1:0] mode_pop(input logic [XLEN-1:0] s);
        logic [XLEN-1:0] r;
        r = s;
        r[MODE_W-3:0] = s[MODE_W-1:2];
        return r;
    endfunction

    function automatic logic swi_ready(input logic [XLEN-1:0] s, input logic [XLEN-1:0] c);
        return (|(s[SWI_LO+SWI_W-1:SWI_LO] & c[SWI_LO+SWI_W-1:SWI_LO])) && s[0];
    endfunction
endpackage

// File: rtl/cp0_status_reg.sv
module cp0_status_reg
    import cp0_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  act_e            act,
    input  logic            wr_hit,
    input  logic [XLEN-1:0] wr_data,
    output logic [XLEN-1:0] status_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else begin
            unique case (act)
                ACT_ENTER, ACT_TAKE: status_q <= mode_push(status_q);
                ACT_POP:             status_q <= mode_pop(status_q);
                ACT_WRITE:           if (wr_hit) status_q <= wr_data;
                default:             status_q <= status_q;
            endcase
        end
    end

    p_pop_upper_r9: assert property (@(posedge clk) disable iff (rst)
        act == ACT_POP |=> status_q[XLEN-1:MODE_W-2] == $past(status_q[XLEN-1:MODE_W-2]));

    p_push_mode_r7: assert property (@(posedge clk) disable iff (rst)
        act == ACT_ENTER |=> status_q[MODE_W-1:0] == {$past(status_q[MODE_W-3:0]), 2'b00});
endmodule

// File: rtl/cp0_cause_reg.sv
module cp0_cause_reg
    import cp0_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  act_e              act,
    input  logic              wr_hit,
    input  logic [SWI_W-1:0]  wr_swi,
    input  logic              ent_bd,
    input  logic [CODE_W-1:0] ent_code,
    output logic [XLEN-1:0]   cause_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
        end else begin
            unique case (act)
                ACT_ENTER: begin
                    cause_q[BD_BIT]                    <= ent_bd;
                    cause_q[CODE_LO+CODE_W-1:CODE_LO]  <= ent_code;
                end
                ACT_TAKE: begin
                    cause_q[BD_BIT]                    <= ent_bd;
                    cause_q[CODE_LO+CODE_W-1:CODE_LO]  <= '0;
                end
                ACT_WRITE: if (wr_hit) cause_q[SWI_LO+SWI_W-1:SWI_LO] <= wr_swi;
                default: cause_q <= cause_q;
            endcase
        end
    end

    p_cause_mask_r3: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_WRITE && wr_hit) |=>
            (cause_q[XLEN-1:SWI_LO+SWI_W] == $past(cause_q[XLEN-1:SWI_LO+SWI_W]))
            && (cause_q[SWI_LO-1:0] == $past(cause_q[SWI_LO-1:0])));

    p_entry_code_r7: assert property (@(posedge clk) disable iff (rst)
        act == ACT_ENTER |=> cause_q[CODE_LO+CODE_W-1:CODE_LO] == $past(ent_code));

    p_take_clear_r6: assert property (@(posedge clk) disable iff (rst)
        act == ACT_TAKE |=> cause_q[CODE_LO+CODE_W-1:CODE_LO] == '0);
endmodule

// File: rtl/cp0_reg_bank.sv
module cp0_reg_bank
    import cp0_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  act_e             act,
    input  logic             wr_hit,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]  wr_data,
    input  logic [XLEN-1:0]  ent_pc,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [XLEN-1:0]  rd_word
);
    logic [XLEN-1:0] bank_q [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) bank_q[i] <= '0;
        end else begin
            if (act == ACT_ENTER || act == ACT_TAKE)
                bank_q[IDX_EPC] <= ent_pc;
            else if (act == ACT_WRITE && wr_hit)
                bank_q[wr_idx] <= wr_data;
        end
    end

    assign rd_word = bank_q[rd_idx];

    p_epc_capture_r7: assert property (@(posedge clk) disable iff (rst)
        act == ACT_ENTER |=> bank_q[IDX_EPC] == $past(ent_pc));
endmodule

// File: rtl/cp0_sysctl.sv
module cp0_sysctl
    import cp0_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]  wr_data,
    input  logic             exc_req,
    input  logic [CODE_W-1:0] exc_code,
    input  logic             exc_in_delay,
    input  logic [XLEN-1:0]  exc_pc,
    input  logic             rfe,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [XLEN-1:0]  status_q,
    output logic [XLEN-1:0]  cause_q,
    output logic [XLEN-1:0]  rd_data,
    output logic             irq_take
);
    act_e   act;
    entry_t ent;
    logic   hit_status, hit_cause, hit_bank, arm_q, arm_d;
    logic [XLEN-1:0] bank_word;

    assign hit_status = (wr_idx == IDX_W'(IDX_STATUS));
    assign hit_cause  = (wr_idx == IDX_W'(IDX_CAUSE));
    assign hit_bank   = !hit_status && !hit_cause;

    assign irq_take = arm_q && swi_ready(status_q, cause_q) && !exc_req;

    always_comb begin
        if (exc_req)       act = ACT_ENTER;
        else if (irq_take) act = ACT_TAKE;
        else if (rfe)      act = ACT_POP;
        else if (wr_en)    act = ACT_WRITE;
        else               act = ACT_IDLE;
    end

    assign ent.bd   = exc_in_delay;
    assign ent.code = exc_code;
    assign ent.pc   = exc_pc;

    assign arm_d = (act == ACT_WRITE) && (hit_status || hit_cause);

    always_ff @(posedge clk) begin
        if (rst) arm_q <= 1'b0;
        else     arm_q <= arm_d;
    end

    cp0_status_reg u_status (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .wr_hit   (hit_status),
        .wr_data  (wr_data),
        .status_q (status_q)
    );

    cp0_cause_reg u_cause (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .wr_hit   (hit_cause),
        .wr_swi   (wr_data[SWI_LO+SWI_W-1:SWI_LO]),
        .ent_bd   (ent.bd),
        .ent_code (ent.code),
        .cause_q  (cause_q)
    );

    cp0_reg_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .act     (act),
        .wr_hit  (hit_bank),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .ent_pc  (ent.pc),
        .rd_idx  (rd_idx),
        .rd_word (bank_word)
    );

    always_comb begin
        if (rd_idx == IDX_W'(IDX_STATUS))     rd_data = status_q;
        else if (rd_idx == IDX_W'(IDX_CAUSE)) rd_data = cause_q;
        else                                  rd_data = bank_word;
    end

    p_take_armed_r5: assert property (@(posedge clk) disable iff (rst)
        irq_take |-> $past(wr_en && !exc_req && !rfe && (hit_status || hit_cause)));

    p_take_once_r6: assert property (@(posedge clk) disable iff (rst)
        irq_take |=> !irq_take);

    p_take_ie_r5: assert property (@(posedge clk) disable iff (rst)
        irq_take |-> status_q[0] && !exc_req);
endmodule

// File: tb/tb_cp0_sysctl.sv
module tb_cp0_sysctl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        exc_req = 1'b0;
    logic [4:0]  exc_code = '0;
    logic        exc_in_delay = 1'b0;
    logic [31:0] exc_pc = '0;
    logic        rfe = 1'b0;
    logic [4:0]  rd_idx = '0;
    logic [31:0] status_q, cause_q, rd_data;
    logic        irq_take;

    always #4 clk = ~clk;

    cp0_sysctl dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .exc_req(exc_req), .exc_code(exc_code), .exc_in_delay(exc_in_delay),
        .exc_pc(exc_pc), .rfe(rfe), .rd_idx(rd_idx),
        .status_q(status_q), .cause_q(cause_q), .rd_data(rd_data), .irq_take(irq_take)
    );

    typedef struct {
        int          sel;
        logic [31:0] val;
        string       req;
    } exp_t;

    exp_t        q[$];
    int          total = 0;
    int          bad = 0;
    bit          done = 0;
    logic [31:0] m_status = '0, m_cause = '0;
    logic [31:0] m_bank [32];
    bit          m_arm = 0;

    function automatic bit m_ready();
        return ((m_status & m_cause & 32'h300) != 0) && m_status[0];
    endfunction

    function automatic logic [31:0] m_read(input logic [4:0] i);
        if (i == 5'd12) return m_status;
        if (i == 5'd13) return m_cause;
        return m_bank[i];
    endfunction

    function automatic void push(input int sel, input logic [31:0] v, input string r);
        exp_t e;
        e.sel = sel; e.val = v; e.req = r;
        q.push_back(e);
    endfunction

    function automatic void push_all(input logic [4:0] ridx, input logic cur_exc, input string r);
        push(0, m_status, r);
        push(1, m_cause, r);
        push(2, m_read(ridx), r);
        push(3, {31'b0, m_arm && m_ready() && !cur_exc}, r);
    endfunction

    // monitor: compares queued expectations 2 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0) begin
                exp_t e;
                logic [31:0] act;
                string nm;
                e = q.pop_front();
                case (e.sel)
                    0: begin act = status_q; nm = "status"; end
                    1: begin act = cause_q; nm = "cause"; end
                    2: begin act = rd_data; nm = "rd_data"; end
                    default: begin act = {31'b0, irq_take}; nm = "irq_take"; end
                endcase
                total++;
                if (act !== e.val) begin
                    bad++;
                    $display("FAIL %s %s actual=%h expected=%h", e.req, nm, act, e.val);
                end
            end
        end
    end

    task automatic step(input logic wen, input logic [4:0] idx, input logic [31:0] d,
                        input logic exc, input logic [4:0] code, input logic bd,
                        input logic [31:0] pc, input logic rf, input logic [4:0] ridx,
                        input string r);
        bit take;
        @(negedge clk);
        wr_en = wen; wr_idx = idx; wr_data = d; exc_req = exc; exc_code = code;
        exc_in_delay = bd; exc_pc = pc; rfe = rf; rd_idx = ridx;
        take = m_arm && m_ready() && !exc;
        @(posedge clk);
        if (exc || take) begin
            m_status[5:0] = {m_status[3:0], 2'b00};
            m_cause[31]   = bd;
            m_cause[6:2]  = exc ? code : 5'd0;
            m_bank[14]    = pc;
            m_arm = 0;
        end else if (rf) begin
            m_status[3:0] = m_status[5:2];
            m_arm = 0;
        end else if (wen) begin
            if (idx == 5'd12) m_status = d;
            else if (idx == 5'd13) m_cause[9:8] = d[9:8];
            else m_bank[idx] = d;
            m_arm = (idx == 5'd12) || (idx == 5'd13);
        end else begin
            m_arm = 0;
        end
        #1;
        push_all(ridx, exc, r);
    endtask

    task automatic idle(input logic [4:0] ridx, input string r);
        step(0, 0, 0, 0, 0, 0, 0, 0, ridx, r);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) m_bank[i] = '0;
        // R1: values held during reset
        repeat (2) @(posedge clk);
        #1;
        push_all(5'd14, 1'b0, "R1");
        @(negedge clk);
        rst = 0;
        idle(5'd3, "R1");
        // R4: plain index store and read back
        step(1, 5'd5, 32'hDEAD_BEEF, 0, 0, 0, 0, 0, 5'd5, "R4");
        step(1, 5'd14, 32'h1234_5678, 0, 0, 0, 0, 0, 5'd14, "R4");
        // R2: full status replace, no interrupt since cause has no pending bits
        step(1, 5'd12, 32'hA5A0_0101, 0, 0, 0, 0, 0, 5'd12, "R2");
        idle(5'd12, "R5");
        // R3 and R5: cause write keeps only bits 9:8, arms interrupt
        step(1, 5'd13, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 5'd13, "R3");
        // R6: interrupt entry lands on this edge
        step(0, 0, 0, 0, 0, 1, 32'h0000_0400, 0, 5'd14, "R6");
        idle(5'd13, "R6");
        // R7 and R8: system call entry with code 8
        step(0, 0, 0, 1, 5'd8, 0, 32'h0000_0800, 0, 5'd14, "R8");
        step(0, 0, 0, 1, 5'd13, 1, 32'h0000_0900, 0, 5'd13, "R7");
        // R9: pop, upper bits kept
        step(0, 0, 0, 0, 0, 0, 0, 1, 5'd12, "R9");
        step(1, 5'd12, 32'h0000_003C, 0, 0, 0, 0, 0, 5'd12, "R2");
        step(0, 0, 0, 0, 0, 0, 0, 1, 5'd12, "R9");
        // R10: exception beats pop and write in the same cycle
        step(1, 5'd6, 32'h0BAD_F00D, 1, 5'd4, 0, 32'h0000_0A00, 1, 5'd6, "R10");
        // R10: pop beats write
        step(1, 5'd12, 32'hFFFF_FFFF, 0, 0, 0, 0, 1, 5'd12, "R10");
        // R5: interrupt enable clear, no take
        step(1, 5'd12, 32'h0000_0300, 0, 0, 0, 0, 0, 5'd12, "R5");
        idle(5'd12, "R5");
        // R10: armed interrupt suppressed by simultaneous exception
        step(1, 5'd12, 32'h0000_0201, 0, 0, 0, 0, 0, 5'd12, "R5");
        step(0, 0, 0, 1, 5'd10, 1, 32'h0000_0C00, 0, 5'd14, "R10");
        idle(5'd13, "R10");
        // R10: armed interrupt beats a pop and a write
        step(1, 5'd13, 32'h0000_0200, 0, 0, 0, 0, 0, 5'd13, "R3");
        step(1, 5'd12, 32'h0000_0201, 0, 0, 0, 0, 0, 5'd12, "R5");
        step(1, 5'd7, 32'h7777_7777, 0, 0, 0, 32'h0000_0D00, 1, 5'd7, "R10");
        idle(5'd14, "R6");
        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule